// File: doc/BRIEF.md
# Parallel Image Sensor Output Timer

This block drives the parallel video output of a small image sensor. It produces a pixel clock, a frame-valid strobe, a line-valid strobe and a 10-bit data bus that walks a raster of active rows and columns. Vertical and horizontal blanking sit between the active rows and frames. Pixel values come from an internal counter pattern instead of a pixel array, so a receiver or a bench can check pixel order and pixel count.

The block runs on an internal clock at twice the master rate. One internal tick is half a master clock. The pixel clock has a period of four ticks: two high and two low. A 3-bit skew code moves the pixel clock edges relative to the data in steps of one tick. The active size, the blanking lengths, the frame-valid margins and the skew code are plain configuration inputs. They are captured once per frame, at the start of vertical blanking.

All lengths below are counted in pixel slots. A pixel slot is one pixel clock period, or four ticks. A configured length of zero acts as one.

Top module: `pix_out_timer`

## Requirements
- R1: While reset is low, frame_valid, line_valid, pix_clk and pix_data are all zero.
- R2: pix_clk is high for exactly two ticks and then low for exactly two ticks. It keeps running through horizontal and vertical blanking.
- R3: pix_data, line_valid and frame_valid change only on slot boundaries, once every four ticks. While line_valid is high, exactly one pixel word is presented per pix_clk period.
- R4: The pix_clk rising edge comes a fixed number of ticks after each slot boundary, set by cfg_skew. Code 0 gives 3 ticks (one master clock early), code 1 gives 0, code 2 gives 1 (the default of half a master clock), code 3 gives 2 and code 4 gives 3 (one master clock late). Codes 5 to 7 act as code 2.
- R5: pix_data is zero in every tick where line_valid is low.
- R6: Each frame has cfg_rows lines. Each line has line_valid high for cfg_cols slots. Consecutive lines are separated by cfg_hblank slots of horizontal blanking. line_valid is high only while frame_valid is high.
- R7: line_valid first rises cfg_lead slots after frame_valid rises. frame_valid falls cfg_tail slots after the last line_valid falls.
- R8: frame_valid stays low for cfg_vblank × (cfg_cols + cfg_hblank) slots before each frame.
- R9: A configured count of zero (cfg_hblank, cfg_lead and the other lengths) behaves as a count of one.
- R10: All configuration inputs, including cfg_skew, are captured when vertical blanking starts. Changes made while a frame is running have no effect until the next frame.
- R11: The pixel pattern starts at 0 on the first pixel of each frame and increases by one per active pixel, wrapping modulo 1024.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock, twice the master rate |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_cols | input | 10 | Active pixels per line |
| cfg_rows | input | 9 | Active lines per frame |
| cfg_hblank | input | 10 | Horizontal blanking, in slots |
| cfg_vblank | input | 9 | Vertical blanking, in row times |
| cfg_lead | input | 10 | Slots from frame_valid rise to first line_valid |
| cfg_tail | input | 10 | Slots from last line_valid fall to frame_valid fall |
| cfg_skew | input | 3 | Pixel clock skew code |
| pix_clk | output | 1 | Pixel clock, half the master rate |
| frame_valid | output | 1 | High during the rows of a frame |
| line_valid | output | 1 | High during active pixels of a line |
| pix_data | output | 10 | Pixel word, zero during blanking |

## Verification
Every output is registered. A new slot value therefore appears in the tick right after the edge that ends the previous slot, and pix_clk rises 0 to 3 ticks later, depending on the captured skew code. The monitor samples once per tick on the falling clock. It pops one expected pixel at each pix_clk rising sample while line_valid is high, so every pixel is taken from inside its own slot whatever the skew. Lengths are checked as tick differences between strobe edges and compared with four times the expected slot count. The expected configuration for each frame is pushed when it is applied. The next configuration is then applied while the current frame is still running, which checks R10.

// File: rtl/pot_pkg.sv
package pot_pkg;

    typedef enum logic [2:0] {
        ST_VBL  = 3'd0,
        ST_LEAD = 3'd1,
        ST_LINE = 3'd2,
        ST_HBL  = 3'd3,
        ST_TAIL = 3'd4
    } pot_state_e;

    // tick (0..3) inside a slot at which the pixel clock rises
    function automatic logic [1:0] rise_tick(input logic [2:0] code);
        case (code)
            3'd0:    return 2'd3;
            3'd1:    return 2'd0;
            3'd2:    return 2'd1;
            3'd3:    return 2'd2;
            3'd4:    return 2'd3;
            default: return 2'd1;
        endcase
    endfunction

endpackage

// File: rtl/pot_phase.sv
module pot_phase
    import pot_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] skew,
    output logic       slot_end,
    output logic [1:0] phase,
    output logic       pix_clk
);

    typedef struct packed {
        logic [1:0] ph;
        logic       pclk;
    } ph_t;

    ph_t q, d;

    always_comb begin
        d      = q;
        d.ph   = q.ph + 2'd1;
        // high for the two ticks starting at the rise tick
        d.pclk = ((d.ph - rise_tick(skew)) < 2'd2);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign slot_end = (q.ph == 2'd3);
    assign phase    = q.ph;
    assign pix_clk  = q.pclk;

endmodule

// File: rtl/pot_raster.sv
module pot_raster
    import pot_pkg::*;
#(
    parameter int COL_W  = 10,
    parameter int ROW_W  = 9,
    parameter int BLK_W  = 10,
    parameter int DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slot_end,
    input  logic [COL_W-1:0]  cfg_cols,
    input  logic [ROW_W-1:0]  cfg_rows,
    input  logic [BLK_W-1:0]  cfg_hblank,
    input  logic [ROW_W-1:0]  cfg_vblank,
    input  logic [BLK_W-1:0]  cfg_lead,
    input  logic [BLK_W-1:0]  cfg_tail,
    input  logic [2:0]        cfg_skew,
    output logic [2:0]        skew_cur,
    output logic              frame_valid,
    output logic              line_valid,
    output logic [DATA_W-1:0] pix_data
);

    localparam int CNT_W = ((COL_W > BLK_W) ? COL_W : BLK_W) + 1;

    typedef struct packed {
        pot_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic [ROW_W-1:0]  row;
        logic [DATA_W-1:0] pix;
        logic [COL_W-1:0]  cols;
        logic [ROW_W-1:0]  rows;
        logic [BLK_W-1:0]  hb;
        logic [BLK_W-1:0]  lead;
        logic [BLK_W-1:0]  tail;
        logic [2:0]        skew;
        logic              fv;
        logic              lv;
        logic [DATA_W-1:0] data;
    } rs_t;

    rs_t q, d;

    function automatic logic [CNT_W-1:0] ldc(input logic [CNT_W-1:0] n);
        return (n == '0) ? '0 : n - 1'b1;
    endfunction

    function automatic logic [ROW_W-1:0] ldr(input logic [ROW_W-1:0] n);
        return (n == '0) ? '0 : n - 1'b1;
    endfunction

    function automatic logic [CNT_W-1:0] eff(input logic [CNT_W-1:0] n);
        return (n == '0) ? CNT_W'(1) : n;
    endfunction

    always_comb begin
        d = q;
        if (slot_end) begin
            if (q.cnt != '0) begin
                d.cnt = q.cnt - 1'b1;
            end else begin
                case (q.st)
                    ST_TAIL: begin
                        d.cols = cfg_cols;
                        d.rows = cfg_rows;
                        d.hb   = cfg_hblank;
                        d.lead = cfg_lead;
                        d.tail = cfg_tail;
                        d.skew = cfg_skew;
                        d.st   = ST_VBL;
                        d.cnt  = eff(CNT_W'(cfg_cols)) + eff(CNT_W'(cfg_hblank)) - 1'b1;
                        d.row  = ldr(cfg_vblank);
                        d.pix  = '0;
                    end
                    ST_VBL: begin
                        if (q.row == '0) begin
                            d.st  = ST_LEAD;
                            d.cnt = ldc(CNT_W'(q.lead));
                        end else begin
                            d.row = q.row - 1'b1;
                            d.cnt = eff(CNT_W'(q.cols)) + eff(CNT_W'(q.hb)) - 1'b1;
                        end
                    end
                    ST_LEAD: begin
                        d.st  = ST_LINE;
                        d.cnt = ldc(CNT_W'(q.cols));
                        d.row = ldr(q.rows);
                    end
                    ST_LINE: begin
                        if (q.row == '0) begin
                            d.st  = ST_TAIL;
                            d.cnt = ldc(CNT_W'(q.tail));
                        end else begin
                            d.st  = ST_HBL;
                            d.cnt = ldc(CNT_W'(q.hb));
                        end
                    end
                    ST_HBL: begin
                        d.st  = ST_LINE;
                        d.row = q.row - 1'b1;
                        d.cnt = ldc(CNT_W'(q.cols));
                    end
                    default: begin
                        d.st  = ST_TAIL;
                        d.cnt = '0;
                    end
                endcase
            end
            // registered outputs for the slot that starts now
            d.fv   = (d.st == ST_LEAD) || (d.st == ST_LINE) ||
                     (d.st == ST_HBL)  || (d.st == ST_TAIL);
            d.lv   = (d.st == ST_LINE);
            d.data = '0;
            if (d.st == ST_LINE) begin
                d.data = q.pix;
                d.pix  = q.pix + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_TAIL;
            q.skew <= 3'd2;
        end else begin
            q <= d;
        end
    end

    assign skew_cur    = q.skew;
    assign frame_valid = q.fv;
    assign line_valid  = q.lv;
    assign pix_data    = q.data;

endmodule

// File: rtl/pix_out_timer.sv
module pix_out_timer #(
    parameter int COL_W  = 10,
    parameter int ROW_W  = 9,
    parameter int BLK_W  = 10,
    parameter int DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [COL_W-1:0]  cfg_cols,
    input  logic [ROW_W-1:0]  cfg_rows,
    input  logic [BLK_W-1:0]  cfg_hblank,
    input  logic [ROW_W-1:0]  cfg_vblank,
    input  logic [BLK_W-1:0]  cfg_lead,
    input  logic [BLK_W-1:0]  cfg_tail,
    input  logic [2:0]        cfg_skew,
    output logic              pix_clk,
    output logic              frame_valid,
    output logic              line_valid,
    output logic [DATA_W-1:0] pix_data
);

    logic       slot_end;
    logic [1:0] phase;
    logic [2:0] skew_cur;

    pot_phase u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .skew     (skew_cur),
        .slot_end (slot_end),
        .phase    (phase),
        .pix_clk  (pix_clk)
    );

    pot_raster #(
        .COL_W  (COL_W),
        .ROW_W  (ROW_W),
        .BLK_W  (BLK_W),
        .DATA_W (DATA_W)
    ) u_raster (
        .clk         (clk),
        .rst_n       (rst_n),
        .slot_end    (slot_end),
        .cfg_cols    (cfg_cols),
        .cfg_rows    (cfg_rows),
        .cfg_hblank  (cfg_hblank),
        .cfg_vblank  (cfg_vblank),
        .cfg_lead    (cfg_lead),
        .cfg_tail    (cfg_tail),
        .cfg_skew    (cfg_skew),
        .skew_cur    (skew_cur),
        .frame_valid (frame_valid),
        .line_valid  (line_valid),
        .pix_data    (pix_data)
    );

endmodule

// File: rtl/pot_checker.sv
module pot_checker #(
    parameter int DATA_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pix_clk,
    input logic              frame_valid,
    input logic              line_valid,
    input logic [DATA_W-1:0] pix_data,
    input logic [1:0]        phase
);

    AST_LV_INSIDE_FV: assert property (@(posedge clk) disable iff (!rst_n)
        line_valid |-> frame_valid); // R6

    AST_BLANK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !line_valid |-> (pix_data == '0)); // R5

    AST_SLOT_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(pix_data) || !$stable(line_valid) || !$stable(frame_valid))
        |-> (phase == 2'd0)); // R3

    AST_PCLK_HIGH_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid && pix_clk && $past(pix_clk)) |=> !pix_clk); // R2

    AST_PCLK_LOW_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid && !pix_clk && !$past(pix_clk)) |=> pix_clk); // R2

endmodule

bind pix_out_timer pot_checker #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pix_clk     (pix_clk),
    .frame_valid (frame_valid),
    .line_valid  (line_valid),
    .pix_data    (pix_data),
    .phase       (phase)
);

// File: tb/tb_pix_out_timer.sv
`timescale 1ns/1ps
module tb_pix_out_timer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] cfg_cols = '0;
    logic [8:0] cfg_rows = '0;
    logic [9:0] cfg_hblank = '0;
    logic [8:0] cfg_vblank = '0;
    logic [9:0] cfg_lead = '0;
    logic [9:0] cfg_tail = '0;
    logic [2:0] cfg_skew = '0;
    logic       pix_clk, frame_valid, line_valid;
    logic [9:0] pix_data;

    always #4 clk = ~clk; // 125 MHz

    pix_out_timer dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_cols(cfg_cols), .cfg_rows(cfg_rows), .cfg_hblank(cfg_hblank),
        .cfg_vblank(cfg_vblank), .cfg_lead(cfg_lead), .cfg_tail(cfg_tail),
        .cfg_skew(cfg_skew), .pix_clk(pix_clk), .frame_valid(frame_valid),
        .line_valid(line_valid), .pix_data(pix_data)
    );

    typedef struct {
        int cols, rows, hb, vb, lead, tail, skew;
    } fcfg_t;

    localparam int NFRM = 6;
    fcfg_t cfgs [NFRM];
    fcfg_t exp_frm [$];
    int    exp_pix [$];
    int    tests = 0, fails = 0, frames_done = 0;

    function automatic int eff(input int n);
        return (n == 0) ? 1 : n;
    endfunction

    function automatic int rise_of(input int code);
        case (code)
            0: return 3; 1: return 0; 2: return 1; 3: return 2; 4: return 3;
            default: return 1;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // driver: apply a configuration and push what it must produce
    task automatic apply(input fcfg_t c);
        cfg_cols   = 10'(c.cols);
        cfg_rows   = 9'(c.rows);
        cfg_hblank = 10'(c.hb);
        cfg_vblank = 9'(c.vb);
        cfg_lead   = 10'(c.lead);
        cfg_tail   = 10'(c.tail);
        cfg_skew   = 3'(c.skew);
        exp_frm.push_back(c);
        for (int i = 0; i < eff(c.cols) * eff(c.rows); i++)
            exp_pix.push_back(i % 1024); // R11
    endtask

    // monitor state
    fcfg_t cur;
    bit    active = 0, have_fall = 0, skew_wait = 0;
    bit    p_pclk = 0, p_lv = 0, p_fv = 0;
    int    t = 0, last_edge = -1, t_fv_rise = 0, t_fv_fall = 0;
    int    t_lv_rise = 0, t_lv_fall = 0, lines = 0;

    initial begin
        wait (rst_n);
        forever begin
            @(negedge clk);
            t++;
            chk(line_valid || pix_data == 10'd0, "R5", int'(pix_data), 0);
            if (pix_clk != p_pclk) begin
                if (frame_valid && last_edge >= 0)
                    chk(t - last_edge == 2, "R2", t - last_edge, 2);
                last_edge = t;
            end
            if (frame_valid && !p_fv) begin
                active = (exp_frm.size() != 0);
                if (active) begin
                    cur = exp_frm.pop_front();
                    if (have_fall)
                        chk(t - t_fv_fall == 4 * eff(cur.vb) * (eff(cur.cols) + eff(cur.hb)),
                            "R8", t - t_fv_fall,
                            4 * eff(cur.vb) * (eff(cur.cols) + eff(cur.hb)));
                end
                t_fv_rise = t;
                lines = 0;
            end
            if (active && line_valid && !p_lv) begin
                lines++;
                if (lines == 1) begin
                    chk(t - t_fv_rise == 4 * eff(cur.lead), (cur.lead == 0) ? "R9" : "R7",
                        t - t_fv_rise, 4 * eff(cur.lead));
                    skew_wait = 1;
                end else begin
                    chk(t - t_lv_fall == 4 * eff(cur.hb), (cur.hb == 0) ? "R9" : "R6",
                        t - t_lv_fall, 4 * eff(cur.hb));
                end
                t_lv_rise = t;
            end
            if (pix_clk && !p_pclk) begin
                if (active && skew_wait) begin
                    chk(t - t_lv_rise == rise_of(cur.skew), "R4", t - t_lv_rise,
                        rise_of(cur.skew));
                    skew_wait = 0;
                end
                if (active && line_valid) begin
                    if (exp_pix.size() == 0) chk(0, "R3", int'(pix_data), -1);
                    else begin
                        int e;
                        e = exp_pix.pop_front();
                        chk(int'(pix_data) == e, "R11", int'(pix_data), e);
                    end
                end
            end
            if (active && !line_valid && p_lv) begin
                chk(t - t_lv_rise == 4 * eff(cur.cols), "R6", t - t_lv_rise, 4 * eff(cur.cols));
                t_lv_fall = t;
            end
            if (active && !frame_valid && p_fv) begin
                chk(lines == eff(cur.rows), "R6", lines, eff(cur.rows));
                chk(t - t_lv_fall == 4 * eff(cur.tail), "R7", t - t_lv_fall, 4 * eff(cur.tail));
                t_fv_fall = t;
                have_fall = 1;
                frames_done++;
            end
            p_pclk = pix_clk;
            p_lv   = line_valid;
            p_fv   = frame_valid;
        end
    end

    initial begin
        cfgs[0] = '{8, 3, 3, 2, 2, 1, 2};
        cfgs[1] = '{40, 30, 2, 1, 1, 2, 0};
        cfgs[2] = '{5, 2, 0, 3, 0, 3, 1};
        cfgs[3] = '{6, 4, 1, 1, 3, 2, 3};
        cfgs[4] = '{3, 2, 2, 2, 1, 1, 4};
        cfgs[5] = '{4, 2, 1, 1, 2, 4, 6};
        apply(cfgs[0]);
        repeat (5) @(negedge clk);
        chk(frame_valid == 1'b0, "R1", int'(frame_valid), 0);
        chk(line_valid == 1'b0, "R1", int'(line_valid), 0);
        chk(pix_data == 10'd0, "R1", int'(pix_data), 0);
        chk(pix_clk == 1'b0, "R1", int'(pix_clk), 0);
        rst_n = 1'b1;
        // R10: each next setup is applied while the current frame runs
        for (int k = 1; k < NFRM; k++) begin
            @(posedge frame_valid);
            #1;
            apply(cfgs[k]);
        end
        wait (frames_done == NFRM);
        repeat (4) @(negedge clk);
        chk(exp_pix.size() == 0, "R3", exp_pix.size(), 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog frames=%0d expected=%0d", frames_done, NFRM);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule